// File: doc/BRIEF.md
# Processor Flag and Control Unit

This unit carries out one-byte control opcodes for a small 16-bit core. It keeps three single-bit flags: carry, direction and interrupt enable. Opcodes that edit those flags act on them directly. The unit also sequences the opcodes that stall or steer the core: a fixed-length no-operation, a halt that only an enabled interrupt ends, a wait that lasts as long as the TEST pin stays high, a bus-lock prefix, and an escape that hands the bus to an external device.

The decoder upstream presents an opcode byte with a valid strobe. The unit accepts it only while `ready` is high. Each accepted opcode that the unit recognises produces one IP-advance pulse. A separate load port writes all three flags at once. It is the only path by which a whole flag word reaches the unit.

Top module: `ctl_unit`

## Requirements
- R1: During reset and in the first cycle after it, all three flags are 0, `ready` is 1, and `halted`, `bus_lock`, `bus_release` and `ip_inc` are 0.
- R2: An accepted 0xF8 clears carry, 0xF9 sets carry and 0xF5 inverts carry. The new value shows in the cycle after acceptance, and the direction and interrupt flags do not change.
- R3: An accepted 0xFC clears direction, 0xFD sets direction, 0xFA clears interrupt enable and 0xFB sets it. The new value shows in the cycle after acceptance, and carry does not change.
- R4: When `flag_load` is high at a clock edge, the flags take `flag_word` (bit 0 carry, bit 1 direction, bit 2 interrupt enable) in the next cycle. This load wins over any flag opcode accepted in the same cycle.
- R5: An opcode is accepted when `op_valid` and `ready` are both high at an edge. Each accepted recognised opcode raises `ip_inc` for exactly the one cycle after acceptance.
- R6: An accepted 0x90 holds `ready` low for exactly 4 cycles after acceptance and changes no flag.
- R7: An accepted 0xF4 raises `halted` and drops `ready` from the next cycle. The unit stays halted until an edge at which `irq` is 1 and interrupt enable is 1. Both signals then recover in the following cycle. `irq` has no effect while interrupt enable is 0.
- R8: An accepted 0x9B drops `ready` from the next cycle. Each busy cycle samples `test_n`, and `ready` returns in the cycle after `test_n` is sampled low.
- R9: An accepted 0xF0 raises `bus_lock` from the next cycle. The output stays high until `insn_done` is sampled high at a later edge, and drops in the cycle after that edge.
- R10: An accepted opcode in 0xD8 to 0xDF raises `bus_release` for exactly the one cycle after acceptance.
- R11: `op_valid` is ignored while `ready` is low. An opcode outside the set above changes no flag, no output and no sequencing state, and raises no `ip_inc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode byte is valid |
| op_byte | input | 8 | Decoded control opcode |
| irq | input | 1 | Interrupt request |
| test_n | input | 1 | Active-low TEST pin |
| insn_done | input | 1 | Completion strobe of the current instruction |
| flag_load | input | 1 | Load all three flags from `flag_word` |
| flag_word | input | 3 | Flag value to load: {interrupt, direction, carry} |
| carry | output | 1 | Carry flag |
| direction | output | 1 | Direction flag |
| intr_en | output | 1 | Interrupt enable flag |
| ip_inc | output | 1 | Pulse: advance the instruction pointer by one |
| ready | output | 1 | Unit can accept an opcode |
| halted | output | 1 | Unit is in the halt state |
| bus_lock | output | 1 | Bus is locked against other masters |
| bus_release | output | 1 | Pulse: bus handed to an external device |

## Verification
Every output is a register, so a flag edit, `ip_inc`, `bus_release` and the first stall cycle each show up exactly one cycle after the accepting edge. The `ready` and `halted` recoveries show up one cycle after the edge that samples the exit condition (`test_n` low, an enabled `irq`, or the fourth no-op cycle). The bench keeps a behavioural model that steps at each rising edge on the same inputs. It compares every output at the falling edge in between, so each check lands in the cycle where the result is due. Directed runs cover the corner cases: a load and a flag opcode in the same cycle, opcodes offered while the unit is busy, an interrupt while interrupt enable is clear, and the lock carried over to the next instruction. A long pseudo-random run then mixes all of these.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OP_W = 8;
    localparam int FL_W = 3;

    localparam logic [OP_W-1:0] OPC_CLC  = 8'hF8;
    localparam logic [OP_W-1:0] OPC_STC  = 8'hF9;
    localparam logic [OP_W-1:0] OPC_CMC  = 8'hF5;
    localparam logic [OP_W-1:0] OPC_CLD  = 8'hFC;
    localparam logic [OP_W-1:0] OPC_STD  = 8'hFD;
    localparam logic [OP_W-1:0] OPC_CLI  = 8'hFA;
    localparam logic [OP_W-1:0] OPC_STI  = 8'hFB;
    localparam logic [OP_W-1:0] OPC_HLT  = 8'hF4;
    localparam logic [OP_W-1:0] OPC_NOP  = 8'h90;
    localparam logic [OP_W-1:0] OPC_WAIT = 8'h9B;
    localparam logic [OP_W-1:0] OPC_LOCK = 8'hF0;
    localparam logic [4:0]      OPC_ESC_HI = 5'b11011;

    typedef enum logic [3:0] {
        OK_NONE, OK_CLC, OK_STC, OK_CMC, OK_CLD, OK_STD, OK_CLI, OK_STI,
        OK_HLT, OK_NOP, OK_WAIT, OK_LOCK, OK_ESC
    } op_kind_e;

    typedef enum logic [1:0] {
        SQ_RUN, SQ_NOP, SQ_HALT, SQ_WAIT
    } sq_state_e;

    // bit 2 interrupt enable, bit 1 direction, bit 0 carry
    typedef struct packed {
        logic ie;
        logic df;
        logic cf;
    } flags_t;

    function automatic op_kind_e classify(input logic [OP_W-1:0] b);
        op_kind_e k;
        k = OK_NONE;
        if (b[7:3] == OPC_ESC_HI) begin
            k = OK_ESC;
        end else begin
            case (b)
                OPC_CLC:  k = OK_CLC;
                OPC_STC:  k = OK_STC;
                OPC_CMC:  k = OK_CMC;
                OPC_CLD:  k = OK_CLD;
                OPC_STD:  k = OK_STD;
                OPC_CLI:  k = OK_CLI;
                OPC_STI:  k = OK_STI;
                OPC_HLT:  k = OK_HLT;
                OPC_NOP:  k = OK_NOP;
                OPC_WAIT: k = OK_WAIT;
                OPC_LOCK: k = OK_LOCK;
                default:  k = OK_NONE;
            endcase
        end
        return k;
    endfunction

    function automatic logic touches_carry(input op_kind_e k);
        return (k == OK_CLC) || (k == OK_STC) || (k == OK_CMC);
    endfunction

    function automatic logic touches_ctrl(input op_kind_e k);
        return (k == OK_CLD) || (k == OK_STD) || (k == OK_CLI) || (k == OK_STI);
    endfunction

endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_byte,
    input  logic            ready,
    output logic            accept,
    output op_kind_e        kind
);

    always_comb begin
        kind   = classify(op_byte);
        accept = op_valid && ready && (kind != OK_NONE);
    end

    // R11
    unknown_never_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_byte == 8'h00) |-> !accept);

endmodule

// File: rtl/ctl_flags.sv
module ctl_flags
    import ctl_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  op_kind_e kind,
    input  logic     load,
    input  flags_t   load_val,
    output flags_t   flags
);

    flags_t nxt;

    always_comb begin
        nxt = flags;
        if (load) begin
            nxt = load_val;
        end else if (accept) begin
            case (kind)
                OK_CLC:  nxt.cf = 1'b0;
                OK_STC:  nxt.cf = 1'b1;
                OK_CMC:  nxt.cf = ~flags.cf;
                OK_CLD:  nxt.df = 1'b0;
                OK_STD:  nxt.df = 1'b1;
                OK_CLI:  nxt.ie = 1'b0;
                OK_STI:  nxt.ie = 1'b1;
                default: nxt = flags;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end

    // R2
    cmc_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && kind == OK_CMC && !load) |=> (flags.cf != $past(flags.cf)));

    // R2
    carry_ops_keep_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && touches_carry(kind) && !load) |=> ($stable(flags.df) && $stable(flags.ie)));

    // R3
    ctrl_ops_keep_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && touches_ctrl(kind) && !load) |=> $stable(flags.cf));

    // R4
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (flags == $past(load_val)));

endmodule

// File: rtl/ctl_seq.sv
module ctl_seq
    import ctl_pkg::*;
#(
    parameter int NOP_CYCLES = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  op_kind_e kind,
    input  logic     irq,
    input  logic     ie,
    input  logic     test_n,
    input  logic     insn_done,
    output logic     ready,
    output logic     halted,
    output logic     ip_inc,
    output logic     bus_lock,
    output logic     bus_release
);

    localparam int CNT_W = $clog2(NOP_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(NOP_CYCLES - 1);

    sq_state_e        state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_RUN;
            cnt   <= '0;
        end else begin
            case (state)
                SQ_RUN: begin
                    if (accept) begin
                        case (kind)
                            OK_NOP: begin
                                state <= SQ_NOP;
                                cnt   <= CNT_LOAD;
                            end
                            OK_HLT:  state <= SQ_HALT;
                            OK_WAIT: state <= SQ_WAIT;
                            default: state <= SQ_RUN;
                        endcase
                    end
                end
                SQ_NOP: begin
                    if (cnt == '0) state <= SQ_RUN;
                    else           cnt   <= cnt - 1'b1;
                end
                SQ_HALT: begin
                    if (irq && ie) state <= SQ_RUN;
                end
                SQ_WAIT: begin
                    if (!test_n) state <= SQ_RUN;
                end
                default: state <= SQ_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ip_inc      <= 1'b0;
            bus_release <= 1'b0;
            bus_lock    <= 1'b0;
        end else begin
            ip_inc      <= accept;
            bus_release <= accept && (kind == OK_ESC);
            if (accept && kind == OK_LOCK) bus_lock <= 1'b1;
            else if (insn_done)            bus_lock <= 1'b0;
        end
    end

    always_comb begin
        ready  = (state == SQ_RUN);
        halted = (state == SQ_HALT);
    end

    // R5
    ip_from_accept_chk: assert property (@(posedge clk) disable iff (rst)
        ip_inc |-> $past(accept));

    // R6
    nop_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && kind == OK_NOP) |=> !ready);

    // R6
    nop_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_NOP) |-> (cnt <= CNT_LOAD));

    // R7
    halt_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && !(irq && ie)) |=> halted);

    // R7
    halt_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (halted && irq && ie) |=> (ready && !halted));

    // R8
    wait_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_WAIT && test_n) |=> !ready);

    // R9
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_lock && !insn_done) |=> bus_lock);

    // R10
    release_with_ip_chk: assert property (@(posedge clk) disable iff (rst)
        bus_release |-> ip_inc);

endmodule

// File: rtl/ctl_unit.sv
module ctl_unit
    import ctl_pkg::*;
#(
    parameter int NOP_CYCLES = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_byte,
    input  logic            irq,
    input  logic            test_n,
    input  logic            insn_done,
    input  logic            flag_load,
    input  logic [FL_W-1:0] flag_word,
    output logic            carry,
    output logic            direction,
    output logic            intr_en,
    output logic            ip_inc,
    output logic            ready,
    output logic            halted,
    output logic            bus_lock,
    output logic            bus_release
);

    logic     accept;
    op_kind_e kind;
    flags_t   flags;

    ctl_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_byte  (op_byte),
        .ready    (ready),
        .accept   (accept),
        .kind     (kind)
    );

    ctl_flags u_flags (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .kind     (kind),
        .load     (flag_load),
        .load_val (flags_t'(flag_word)),
        .flags    (flags)
    );

    ctl_seq #(.NOP_CYCLES(NOP_CYCLES)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .kind        (kind),
        .irq         (irq),
        .ie          (flags.ie),
        .test_n      (test_n),
        .insn_done   (insn_done),
        .ready       (ready),
        .halted      (halted),
        .ip_inc      (ip_inc),
        .bus_lock    (bus_lock),
        .bus_release (bus_release)
    );

    always_comb begin
        carry     = flags.cf;
        direction = flags.df;
        intr_en   = flags.ie;
    end

    // R11
    busy_ignores_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !ready && !flag_load) |=> ($stable(flags) && !ip_inc));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (flags == '0 && ready && !bus_lock && !ip_inc && !bus_release));

endmodule

// File: tb/ctl_unit_test.sv
module ctl_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       op_valid = 1'b0;
    logic [7:0] op_byte = 8'h00;
    logic       irq = 1'b0;
    logic       test_n = 1'b1;
    logic       insn_done = 1'b0;
    logic       flag_load = 1'b0;
    logic [2:0] flag_word = 3'b000;
    logic carry, direction, intr_en, ip_inc, ready, halted, bus_lock, bus_release;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    ctl_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_byte(op_byte), .irq(irq),
        .test_n(test_n), .insn_done(insn_done), .flag_load(flag_load),
        .flag_word(flag_word), .carry(carry), .direction(direction),
        .intr_en(intr_en), .ip_inc(ip_inc), .ready(ready), .halted(halted),
        .bus_lock(bus_lock), .bus_release(bus_release)
    );

    // behavioural reference: mode 0 run, 1 no-op count, 2 halted, 3 waiting
    bit m_cf, m_df, m_if, m_ip, m_lock, m_rel;
    int m_mode = 0;
    int m_left = 0;

    always @(posedge clk) begin
        bit known, acc, o_if;
        int o_mode;
        if (rst) begin
            m_cf = 0; m_df = 0; m_if = 0; m_ip = 0; m_lock = 0; m_rel = 0;
            m_mode = 0; m_left = 0;
        end else begin
            o_if = m_if;
            o_mode = m_mode;
            known = (op_byte inside {8'hF8, 8'hF9, 8'hF5, 8'hFC, 8'hFD, 8'hFA, 8'hFB,
                                     8'hF4, 8'h90, 8'h9B, 8'hF0})
                    || (op_byte >= 8'hD8 && op_byte <= 8'hDF);
            acc = op_valid && (o_mode == 0) && known;
            m_ip = acc;
            m_rel = acc && op_byte >= 8'hD8 && op_byte <= 8'hDF;
            if (acc && op_byte == 8'hF0) m_lock = 1;
            else if (insn_done)          m_lock = 0;
            if (flag_load) begin
                m_cf = flag_word[0]; m_df = flag_word[1]; m_if = flag_word[2];
            end else if (acc) begin
                if (op_byte == 8'hF8) m_cf = 0;
                if (op_byte == 8'hF9) m_cf = 1;
                if (op_byte == 8'hF5) m_cf = !m_cf;
                if (op_byte == 8'hFC) m_df = 0;
                if (op_byte == 8'hFD) m_df = 1;
                if (op_byte == 8'hFA) m_if = 0;
                if (op_byte == 8'hFB) m_if = 1;
            end
            if (o_mode == 1) begin
                m_left--;
                if (m_left == 0) m_mode = 0;
            end else if (o_mode == 2) begin
                if (irq && o_if) m_mode = 0;
            end else if (o_mode == 3) begin
                if (!test_n) m_mode = 0;
            end else if (acc) begin
                if (op_byte == 8'h90) begin m_mode = 1; m_left = 4; end
                if (op_byte == 8'hF4) m_mode = 2;
                if (op_byte == 8'h9B) m_mode = 3;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            check(carry == m_cf, "R2", "carry", carry, m_cf);
            check(direction == m_df && intr_en == m_if, "R3", "dir/ie",
                  {direction, intr_en}, {m_df, m_if});
            check(ip_inc == m_ip, "R5", "ip_inc", ip_inc, m_ip);
            check(ready == (m_mode == 0), "R6 R8", "ready", ready, m_mode == 0);
            check(halted == (m_mode == 2), "R7", "halted", halted, m_mode == 2);
            check(bus_lock == m_lock, "R9", "bus_lock", bus_lock, m_lock);
            check(bus_release == m_rel, "R10", "bus_release", bus_release, m_rel);
        end
        if (cycles == 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic issue(input logic [7:0] b);
        op_valid = 1'b1; op_byte = b;
        step();
        op_valid = 1'b0;
    endtask

    initial begin
        step(); step(); step();
        // R1: outputs while reset is held
        check({carry, direction, intr_en, ip_inc, halted, bus_lock, bus_release} == 7'd0
              && ready, "R1", "reset state", {carry, direction, intr_en}, 0);
        rst = 1'b0;
        step();
        check(ready && !halted && !carry, "R1", "after reset", ready, 1);

        issue(8'hF9); issue(8'hF5); issue(8'hF5); issue(8'hF8);
        issue(8'hFD); issue(8'hFC); issue(8'hFB); issue(8'hFA);
        issue(8'hF9);
        // R4: load and flag opcode in the same cycle, load wins
        flag_load = 1'b1; flag_word = 3'b110; op_valid = 1'b1; op_byte = 8'hF5;
        step();
        flag_load = 1'b0; op_valid = 1'b0;
        check(carry == 1'b0 && direction && intr_en, "R4", "load priority",
              {intr_en, direction, carry}, 3'b110);
        issue(8'hFA);

        // R6 and R11: no-op stall, offers during stall ignored
        issue(8'h90);
        op_valid = 1'b1; op_byte = 8'hF9;
        step(); step(); step();
        op_valid = 1'b0;
        check(carry == 1'b0, "R11", "op during stall", carry, 0);
        step(); step();
        issue(8'h00); issue(8'hF6); issue(8'h91);
        check(carry == 1'b0 && !ip_inc, "R11", "unknown opcode", ip_inc, 0);

        // R8: wait with TEST high, then low
        issue(8'h9B);
        repeat (5) step();
        test_n = 1'b0; step(); test_n = 1'b1;
        step();

        // R7: halt, irq ignored while interrupt enable clear
        issue(8'hF4);
        irq = 1'b1; step(); step(); irq = 1'b0;
        check(halted == 1'b1, "R7", "irq with ie clear", halted, 1);
        flag_load = 1'b1; flag_word = 3'b100; step(); flag_load = 1'b0;
        irq = 1'b1; step(); irq = 1'b0; step();
        check(!halted && ready, "R7", "halt exit", halted, 0);

        // R9 and R10: lock over the next instruction, escape range ends
        issue(8'hF0); issue(8'hF9);
        step(); step();
        insn_done = 1'b1; step(); insn_done = 1'b0;
        step();
        issue(8'hD8); issue(8'hDF); issue(8'hE0);
        step();

        // mixed pseudo-random run
        for (int i = 0; i < 4000; i++) begin
            int p;
            p = $urandom % 16;
            op_valid  = ($urandom % 3) == 0;
            case (p)
                0: op_byte = 8'hF8;  1: op_byte = 8'hF9;  2: op_byte = 8'hF5;
                3: op_byte = 8'hFC;  4: op_byte = 8'hFD;  5: op_byte = 8'hFA;
                6: op_byte = 8'hFB;  7: op_byte = 8'hF4;  8: op_byte = 8'h90;
                9: op_byte = 8'h9B;  10: op_byte = 8'hF0; 11: op_byte = 8'hD8 + 8'($urandom % 8);
                default: op_byte = 8'($urandom);
            endcase
            irq       = ($urandom % 4) == 0;
            test_n    = ($urandom % 3) != 0;
            insn_done = ($urandom % 5) == 0;
            flag_load = ($urandom % 16) == 0;
            flag_word = 3'($urandom);
            step();
        end
        op_valid = 1'b0; flag_load = 1'b0; irq = 1'b0; insn_done = 1'b0;
        step(); step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule